// File: doc/BRIEF.md
# Shadow RAM Memory Region Decoder

This block classifies every CPU memory access in a 24-bit physical address space and picks one destination for it: on-board ROM, local shadow RAM, or the external expansion bus. The choice is made per block, from enable and write-protect bitmaps held in a small configuration register file. The register file is loaded through a simple write port and clears to zero on reset.

The window from 0A0000h to 0FFFFFh is split into 16KB shadow RAM blocks. The window from 0C0000h to 0FFFFFh is also split into 32KB ROM blocks and 32KB write-protect blocks. Any access that no enabled block claims goes to the expansion bus. A region at the very top of memory aliases the upper part of the low ROM window, so that the first fetches after a CPU reset can find code. Its size and its destination (ROM or shadow RAM) are both programmable. The block also drives an active-low ROM chip select and flags 16-bit ROM cycles when a width strap asks for them.

The decode is combinational from the address, the write flag and the strobe. Only the configuration registers hold state, so a configuration write changes the decode from the cycle after the clock edge that captures it.

Top module: `shadow_region_decoder`

## Requirements
- R1: Configuration registers are written on a rising clock edge while `cfg_we` is high, at index `cfg_idx`. Index 0 is the ROM enable (bit k enables the 32KB ROM block at 0C0000h+k*32KB). Index 1 holds RAM enables for 16KB blocks 0–7, index 2 for blocks 8–15, index 3 for blocks 16–23; RAM block j starts at 0A0000h+j*16KB and is enabled by bit j mod 8 of its register. Index 4 is the write protect (bit k covers 0C0000h+k*32KB). In index 5, bit 0 picks the small alias and bit 1 redirects the alias to RAM. Indices 6 and 7 have no effect. Reset (synchronous, `rst_n` low) clears all registers.
- R2: A non-aliased access in 0A0000h–0FFFFFh whose 16KB RAM block is enabled selects shadow RAM (`sel_ram`), unless R6 applies.
- R3: A non-aliased access in 0C0000h–0FFFFFh whose 32KB ROM block is enabled, and whose RAM block is disabled, selects ROM (`sel_rom`).
- R4: When both the RAM block and the ROM block are enabled for an address, RAM wins.
- R5: Every other access, including any address below 0A0000h or in 100000h up to the alias region, selects the expansion bus (`sel_ext`).
- R6: A write that would go to shadow RAM in 0C0000h–0FFFFFh, inside a write-protected 32KB block, raises `wr_inhibit` and selects no target. Reads of that block are unaffected.
- R7: With index 5 at zero, any access to FC0000h–FFFFFFh selects ROM, whatever the ROM and RAM enables say. Address FC0000h+x aliases 0C0000h+x.
- R8: With index 5 bit 0 set, only FE0000h–FFFFFFh is aliased (onto 0E0000h–0FFFFFh). FC0000h–FDFFFFh then goes to the expansion bus.
- R9: With index 5 bit 1 set, aliased accesses select shadow RAM instead of ROM, whatever the RAM enables say. The write protection of the aliased low block still applies as in R6.
- R10: `rom_cs_n` is low exactly when ROM is selected.
- R11: `cyc16` is high exactly when ROM is selected and `rom_wide` is high.
- R12: While `strobe` is low, all select lines, `wr_inhibit` and `cyc16` are low and `rom_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | CPU physical byte address |
| wr | input | 1 | 1 = write access, 0 = read |
| strobe | input | 1 | Memory access in progress |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| rom_wide | input | 1 | Width strap: 1 = 16-bit ROM, 0 = 8-bit ROM |
| sel_rom | output | 1 | Access routed to ROM |
| sel_ram | output | 1 | Access routed to local shadow RAM |
| sel_ext | output | 1 | Access routed to the expansion bus |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| wr_inhibit | output | 1 | Write to protected shadow RAM suppressed |
| cyc16 | output | 1 | 16-bit ROM cycle |

## Verification
The assertions assume that `addr`, `wr` and `rom_wide` are stable around the sampling clock edge while `strobe` is high. They also assume that the configuration only changes through the write port, because the checker keeps its own copy of the alias control register by watching that port. The bench changes address and control only on falling edges, and writes configuration in separate cycles. Every result is read late in the low half of the clock, after the last configuration edge has settled.

// File: rtl/sdec_pkg.sv
// Package: shared constants and the target encoding of the region decoder.
// Assumes a 24-bit address space with the low decode window below 1MB.
package sdec_pkg;
    localparam int ADDR_W    = 24;
    localparam int LOW_W     = 20;              // address bits inside the first 1MB
    localparam int CFG_W     = 8;
    localparam int CFG_N     = 6;               // implemented register count
    localparam int CFG_IDX_W = 3;

    // register indices
    localparam int IDX_ROM_EN  = 0;
    localparam int IDX_RAM_EN0 = 1;
    localparam int IDX_WP      = 4;
    localparam int IDX_ALIAS   = 5;

    // alias control bits
    localparam int ALIAS_SMALL_BIT = 0;
    localparam int ALIAS_RAM_BIT   = 1;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_ROM   = 3'd1,
        TGT_RAM   = 3'd2,
        TGT_EXT   = 3'd3,
        TGT_BLOCK = 3'd4
    } target_e;
endpackage

// File: rtl/sdec_cfg_regs.sv
// Module: configuration register file of the region decoder.
// Holds N_REGS byte registers, written one at a time through a single port.
// Assumes synchronous active-low reset; out-of-range indices are dropped.
module sdec_cfg_regs #(
    parameter int N_REGS = sdec_pkg::CFG_N,
    parameter int DATA_W = sdec_pkg::CFG_W,
    parameter int IDX_W  = sdec_pkg::CFG_IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_REGS-1:0][DATA_W-1:0] regs
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        // Load register g when its index is written; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (idx == IDX_W'(g)))
                regs[g] <= wdata;
        end
    end
endmodule

// File: rtl/sdec_alias_map.sv
// Module: detects the top-of-memory alias and folds it onto the low window.
// The large alias covers the top 2^BIG_W bytes, the small one the top
// 2^(BIG_W-1) bytes; both land at the same offset from the top of 1MB.
module sdec_alias_map #(
    parameter int ADDR_W = sdec_pkg::ADDR_W,
    parameter int LOW_W  = sdec_pkg::LOW_W,
    parameter int BIG_W  = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              small_sel,
    output logic              alias_hit,
    output logic [LOW_W-1:0]  eff_addr
);
    localparam int TOP_BIG   = ADDR_W - BIG_W;
    localparam int TOP_SMALL = TOP_BIG + 1;

    logic big_hit, small_hit;

    // Compare the high address bits against all-ones for each alias size.
    always_comb begin
        big_hit   = &addr[ADDR_W-1 -: TOP_BIG];
        small_hit = &addr[ADDR_W-1 -: TOP_SMALL];
        alias_hit = small_sel ? small_hit : big_hit;
    end

    // Build the low-window address: aliased offsets sit at the top of 1MB.
    always_comb begin
        if (alias_hit)
            eff_addr = {{(LOW_W-BIG_W){1'b1}}, addr[BIG_W-1:0]};
        else
            eff_addr = addr[LOW_W-1:0];
    end
endmodule

// File: rtl/sdec_block_lookup.sv
// Module: per-block bitmap lookup inside the first 1MB.
// RAM blocks of 2^RAM_SH bytes start at RAM_BASE; ROM and write-protect
// blocks of 2^ROM_SH bytes start at ROM_BASE. Assumes both windows end at 1MB.
module sdec_block_lookup #(
    parameter int          LOW_W    = sdec_pkg::LOW_W,
    parameter int          RAM_SH   = 14,
    parameter int          ROM_SH   = 15,
    parameter logic [19:0] RAM_BASE = 20'hA0000,
    parameter logic [19:0] ROM_BASE = 20'hC0000
) (
    input  logic [LOW_W-1:0] addr,
    input  logic [((1<<LOW_W)-RAM_BASE)/(1<<RAM_SH)-1:0] ram_map,
    input  logic [((1<<LOW_W)-ROM_BASE)/(1<<ROM_SH)-1:0] rom_map,
    input  logic [((1<<LOW_W)-ROM_BASE)/(1<<ROM_SH)-1:0] wp_map,
    output logic             ram_hit,
    output logic             rom_hit,
    output logic             wp_hit
);
    localparam int RAM_N   = ((1<<LOW_W) - RAM_BASE) / (1<<RAM_SH);
    localparam int ROM_N   = ((1<<LOW_W) - ROM_BASE) / (1<<ROM_SH);
    localparam int RAM_IW  = $clog2(RAM_N);
    localparam int ROM_IW  = $clog2(ROM_N);
    localparam int RAM_TW  = LOW_W - RAM_SH;
    localparam int ROM_TW  = LOW_W - ROM_SH;
    localparam logic [RAM_TW-1:0] RAM_FIRST = RAM_TW'(RAM_BASE >> RAM_SH);
    localparam logic [ROM_TW-1:0] ROM_FIRST = ROM_TW'(ROM_BASE >> ROM_SH);

    logic [RAM_TW-1:0] ram_tag;
    logic [ROM_TW-1:0] rom_tag;
    logic [RAM_TW-1:0] ram_off;
    logic [ROM_TW-1:0] rom_off;
    logic              in_ram_win, in_rom_win;

    // Turn the address into block numbers relative to each window base.
    always_comb begin
        ram_tag    = addr[LOW_W-1:RAM_SH];
        rom_tag    = addr[LOW_W-1:ROM_SH];
        in_ram_win = ram_tag >= RAM_FIRST;
        in_rom_win = rom_tag >= ROM_FIRST;
        ram_off    = ram_tag - RAM_FIRST;
        rom_off    = rom_tag - ROM_FIRST;
    end

    // Index the bitmaps; outside a window a lookup never hits.
    always_comb begin
        ram_hit = in_ram_win && ram_map[ram_off[RAM_IW-1:0]];
        rom_hit = in_rom_win && rom_map[rom_off[ROM_IW-1:0]];
        wp_hit  = in_rom_win && wp_map[rom_off[ROM_IW-1:0]];
    end
endmodule

// File: rtl/shadow_region_decoder.sv
// Module: top of the shadow RAM region decoder.
// Routes each strobed access to ROM, shadow RAM or the expansion bus from
// the configured bitmaps, handles the top-of-memory alias and protected
// writes. Outputs are combinational; only configuration is registered.
module shadow_region_decoder
    import sdec_pkg::*;
#(
    parameter int RAM_BLOCKS = 24,
    parameter int ROM_BLOCKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic                 strobe,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 rom_wide,
    output logic                 sel_rom,
    output logic                 sel_ram,
    output logic                 sel_ext,
    output logic                 rom_cs_n,
    output logic                 wr_inhibit,
    output logic                 cyc16
);
    localparam int RAM_REGS = RAM_BLOCKS / CFG_W;

    logic [CFG_N-1:0][CFG_W-1:0] cfg;
    logic [RAM_BLOCKS-1:0]       ram_map;
    logic [ROM_BLOCKS-1:0]       rom_map;
    logic [ROM_BLOCKS-1:0]       wp_map;
    logic                        alias_hit;
    logic [LOW_W-1:0]            eff_addr;
    logic                        ram_hit, rom_hit, wp_hit;
    logic                        low_meg;
    target_e                     tgt;

    sdec_cfg_regs #(
        .N_REGS (CFG_N),
        .DATA_W (CFG_W),
        .IDX_W  (CFG_IDX_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .regs  (cfg)
    );

    // Gather the RAM enable bytes into one block-ordered bitmap.
    for (genvar r = 0; r < RAM_REGS; r++) begin : g_ram_map
        assign ram_map[r*CFG_W +: CFG_W] = cfg[IDX_RAM_EN0 + r];
    end
    assign rom_map = cfg[IDX_ROM_EN][ROM_BLOCKS-1:0];
    assign wp_map  = cfg[IDX_WP][ROM_BLOCKS-1:0];

    sdec_alias_map #(
        .ADDR_W (ADDR_W),
        .LOW_W  (LOW_W),
        .BIG_W  (18)
    ) u_alias (
        .addr      (addr),
        .small_sel (cfg[IDX_ALIAS][ALIAS_SMALL_BIT]),
        .alias_hit (alias_hit),
        .eff_addr  (eff_addr)
    );

    sdec_block_lookup #(
        .LOW_W    (LOW_W),
        .RAM_SH   (14),
        .ROM_SH   (15),
        .RAM_BASE (20'hA0000),
        .ROM_BASE (20'hC0000)
    ) u_lookup (
        .addr    (eff_addr),
        .ram_map (ram_map),
        .rom_map (rom_map),
        .wp_map  (wp_map),
        .ram_hit (ram_hit),
        .rom_hit (rom_hit),
        .wp_hit  (wp_hit)
    );

    // Flag accesses whose upper address bits are zero (first megabyte).
    assign low_meg = (addr[ADDR_W-1:LOW_W] == '0);

    // Choose one destination by priority: alias, RAM, ROM, then external bus.
    always_comb begin
        tgt = TGT_NONE;
        if (strobe) begin
            if (alias_hit) begin
                if (cfg[IDX_ALIAS][ALIAS_RAM_BIT])
                    tgt = (wr && wp_hit) ? TGT_BLOCK : TGT_RAM;
                else
                    tgt = TGT_ROM;
            end else if (low_meg && ram_hit) begin
                tgt = (wr && wp_hit) ? TGT_BLOCK : TGT_RAM;
            end else if (low_meg && rom_hit) begin
                tgt = TGT_ROM;
            end else begin
                tgt = TGT_EXT;
            end
        end
    end

    // Decode the chosen destination onto the output pins.
    always_comb begin
        sel_rom    = (tgt == TGT_ROM);
        sel_ram    = (tgt == TGT_RAM);
        sel_ext    = (tgt == TGT_EXT);
        wr_inhibit = (tgt == TGT_BLOCK);
        rom_cs_n   = !(tgt == TGT_ROM);
        cyc16      = (tgt == TGT_ROM) && rom_wide;
    end
endmodule

// File: rtl/sdec_checker.sv
// Module: assertion checker for the shadow region decoder, bound to the top.
// Keeps its own copy of the alias control register, taken from the write port.
module sdec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] addr,
    input logic        wr,
    input logic        strobe,
    input logic        cfg_we,
    input logic [2:0]  cfg_idx,
    input logic [7:0]  cfg_wdata,
    input logic        rom_wide,
    input logic        sel_rom,
    input logic        sel_ram,
    input logic        sel_ext,
    input logic        rom_cs_n,
    input logic        wr_inhibit,
    input logic        cyc16
);
    logic mir_small, mir_ram;

    // Track the alias control bits as written through the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mir_small <= 1'b0;
            mir_ram   <= 1'b0;
        end else if (cfg_we && cfg_idx == 3'd5) begin
            mir_small <= cfg_wdata[0];
            mir_ram   <= cfg_wdata[1];
        end
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> !(sel_rom || sel_ram || sel_ext || wr_inhibit || cyc16) && rom_cs_n); // R12
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $countones({sel_rom, sel_ram, sel_ext, wr_inhibit}) == 1); // R5
    AST_CS_FOLLOWS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom == !rom_cs_n); // R10
    AST_WIDE_ONLY_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        cyc16 |-> sel_rom && rom_wide); // R11
    AST_INHIBIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> wr && addr[17:16] != 2'b00 || wr_inhibit |-> wr); // R6
    AST_OUTSIDE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && addr < 24'h0A0000 |-> sel_ext); // R5
    AST_ALIAS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (&addr[23:17]) && !mir_ram |-> sel_rom); // R7
    AST_ALIAS_SMALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && mir_small && addr[23:17] == 7'b1111110 |-> sel_ext); // R8
    AST_ALIAS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (&addr[23:17]) && mir_ram |-> sel_ram || wr_inhibit); // R9
endmodule

bind shadow_region_decoder sdec_checker u_sdec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr         (wr),
    .strobe     (strobe),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .rom_wide   (rom_wide),
    .sel_rom    (sel_rom),
    .sel_ram    (sel_ram),
    .sel_ext    (sel_ext),
    .rom_cs_n   (rom_cs_n),
    .wr_inhibit (wr_inhibit),
    .cyc16      (cyc16)
);

// File: tb/tb_shadow_region_decoder.sv
// Bench: programs a fixed configuration, walks a vector table, then runs
// directed checks for reset, idle strobe, width strap and alias options.
module tb_shadow_region_decoder;
    localparam int CLK_PERIOD = 10;

    // result codes: 0 none, 1 ROM, 2 RAM, 3 external, 4 inhibited
    typedef struct packed {
        logic [23:0] a;
        logic        w;
        logic [2:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{24'h0A0000, 1'b0, 3'd2, 4'd2},  // R2 RAM block 0
        '{24'h0AC000, 1'b1, 3'd2, 4'd2},  // R2 RAM block 3 write
        '{24'h0B0000, 1'b0, 3'd3, 4'd5},  // R5 RAM block 4 off
        '{24'h0C0000, 1'b0, 3'd2, 4'd4},  // R4 RAM beats ROM
        '{24'h0C4000, 1'b1, 3'd4, 4'd6},  // R6 protected write
        '{24'h0C8000, 1'b0, 3'd1, 4'd3},  // R3 ROM block 1
        '{24'h0C8000, 1'b1, 3'd1, 4'd3},  // R3 ROM write
        '{24'h0D0000, 1'b0, 3'd3, 4'd5},  // R5 ROM block 2 off
        '{24'h0F0000, 1'b0, 3'd1, 4'd3},  // R3 ROM block 6
        '{24'h0F8000, 1'b0, 3'd2, 4'd6},  // R6 protected read passes
        '{24'h0FC000, 1'b1, 3'd4, 4'd6},  // R6 protected write top block
        '{24'h09FFFF, 1'b0, 3'd3, 4'd5},  // R5 below window
        '{24'h100000, 1'b0, 3'd3, 4'd5},  // R5 above 1MB
        '{24'hFC0000, 1'b0, 3'd1, 4'd7},  // R7 alias to ROM, enables ignored
        '{24'hFE0000, 1'b1, 3'd1, 4'd7},  // R7 alias write
        '{24'hFBFFFF, 1'b0, 3'd3, 4'd5},  // R5 just below alias
        '{24'h0E0000, 1'b0, 3'd3, 4'd5},  // R5 both enables off
        '{24'h0BC000, 1'b0, 3'd3, 4'd2}   // R2 RAM block 7 off
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        wr = 1'b0;
    logic        strobe = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rom_wide = 1'b0;
    logic        sel_rom, sel_ram, sel_ext, rom_cs_n, wr_inhibit, cyc16;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_region_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .strobe(strobe),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rom_wide(rom_wide), .sel_rom(sel_rom), .sel_ram(sel_ram),
        .sel_ext(sel_ext), .rom_cs_n(rom_cs_n), .wr_inhibit(wr_inhibit),
        .cyc16(cyc16)
    );

    task automatic cfg_write(input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one access on a falling edge and compare outputs late in the low half.
    task automatic access(input logic [23:0] a, input logic w, input logic s,
                          input logic [2:0] exp, input logic exp16, input string tag);
        logic [5:0] got, want;
        @(negedge clk);
        addr = a; wr = w; strobe = s;
        #(CLK_PERIOD/2 - 1);
        got  = {sel_rom, sel_ram, sel_ext, wr_inhibit, rom_cs_n, cyc16};
        want = {exp == 3'd1, exp == 3'd2, exp == 3'd3, exp == 3'd4, exp != 3'd1, exp16};
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s addr=%h wr=%0b got=%b expected=%b", tag, a, w, got, want);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: nothing enabled, alias to ROM
        access(24'h0C0000, 1'b0, 1'b1, 3'd3, 1'b0, "R1 reset low window");
        access(24'h0A0000, 1'b1, 1'b1, 3'd3, 1'b0, "R1 reset RAM off");
        access(24'hFC0000, 1'b0, 1'b1, 3'd1, 1'b0, "R1 reset alias ROM");

        cfg_write(3'd0, 8'b1100_0011);
        cfg_write(3'd1, 8'h0F);
        cfg_write(3'd2, 8'b0000_0011);
        cfg_write(3'd3, 8'b1100_0000);
        cfg_write(3'd4, 8'b1000_0001);

        for (int k = 0; k < NV; k++)
            access(VECS[k].a, VECS[k].w, 1'b1, VECS[k].exp, 1'b0,
                   $sformatf("R%0d vector %0d", VECS[k].req, k));

        // R12 idle strobe
        access(24'h0C8000, 1'b0, 1'b0, 3'd0, 1'b0, "R12 idle ROM address");
        access(24'h0C4000, 1'b1, 1'b0, 3'd0, 1'b0, "R12 idle protected write");

        // R11 width strap; R10 chip select checked in every access
        rom_wide = 1'b1;
        access(24'h0C8000, 1'b0, 1'b1, 3'd1, 1'b1, "R11 wide ROM");
        access(24'h0C0000, 1'b0, 1'b1, 3'd2, 1'b0, "R11 wide RAM no cyc16");
        access(24'hFC0000, 1'b0, 1'b1, 3'd1, 1'b1, "R10 alias ROM wide");
        rom_wide = 1'b0;

        // R1 indices 6 and 7 have no effect
        cfg_write(3'd6, 8'hFF);
        cfg_write(3'd7, 8'hFF);
        access(24'h0D0000, 1'b0, 1'b1, 3'd3, 1'b0, "R1 index 6/7 ignored low");
        access(24'hFC0000, 1'b0, 1'b1, 3'd1, 1'b0, "R1 index 6/7 ignored alias");

        // R8 small alias
        cfg_write(3'd5, 8'h01);
        access(24'hFC0000, 1'b0, 1'b1, 3'd3, 1'b0, "R8 gap goes external");
        access(24'hFDFFFF, 1'b0, 1'b1, 3'd3, 1'b0, "R8 gap top");
        access(24'hFE0000, 1'b0, 1'b1, 3'd1, 1'b0, "R8 small alias ROM");

        // R9 alias to RAM, protection follows the aliased low block
        cfg_write(3'd5, 8'h02);
        access(24'hFC0000, 1'b0, 1'b1, 3'd2, 1'b0, "R9 alias RAM read");
        access(24'hFD0000, 1'b1, 1'b1, 3'd2, 1'b0, "R9 alias RAM write");
        access(24'hFFC000, 1'b1, 1'b1, 3'd4, 1'b0, "R9 alias protected write");
        access(24'hFC4000, 1'b1, 1'b1, 3'd4, 1'b0, "R9 alias block 0 protected");

        // R9 with small alias: gap external, top RAM
        cfg_write(3'd5, 8'h03);
        access(24'hFD0000, 1'b0, 1'b1, 3'd3, 1'b0, "R9 small gap external");
        access(24'hFE8000, 1'b0, 1'b1, 3'd2, 1'b0, "R9 small alias RAM");

        // R1 synchronous reset clears everything again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(24'h0F0000, 1'b0, 1'b1, 3'd3, 1'b0, "R1 re-reset ROM off");
        access(24'hFC0000, 1'b1, 1'b1, 3'd1, 1'b0, "R1 re-reset alias ROM");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule